// File: doc/BRIEF.md
# Paged Word/Byte Program Store

This block is the target-side storage that a programming sequencer writes into. It holds two arrays. The word array is 1K entries of 16 bits, split into 64 pages of 16 words. The byte array is 128 entries of 8 bits, split into 32 pages of 4 bytes. Data is never written to either array directly. Each load strobe places one entry into the page buffer of the selected array. A page-write strobe then merges that whole buffer into one page of the array, at the page named by the upper address bits.

A chip-erase strobe returns both arrays to all ones. When the keep-bytes input is high, the erase leaves the byte array alone. Both page writes and erases take a fixed number of clock cycles, set by a parameter. During that time the ready output stays low, and every strobe that arrives is dropped. Reads are combinational from the applied address and always show array contents, never buffer contents.

Top module: `pfw_store_top`

## Requirements
- R1: After reset, ready_o is high, every word reads 0xFFFF, every byte reads 0xFF, and both page buffers hold all ones.
- R2: A load (load_i high) writes wdata_i into the page buffer of the array selected by target_i, and does not change any array contents. With target_i=0 it writes into the word buffer at slot addr_i[3:0]. With target_i=1 it writes wdata_i[7:0] into the byte buffer at slot addr_i[1:0].
- R3: A page write commits all buffer slots to the page of the selected array in one operation. The word page is addr_i[9:4]; the byte page is addr_i[6:2]. Slot k goes to array location {page, k}. The stored value becomes old AND buffered, so bits can only be cleared.
- R4: After a page write, every slot of the committed buffer holds all ones. A later page write with no loads in between therefore changes nothing.
- R5: A chip erase sets every word to 0xFFFF and clears the word buffer to all ones. It does the same for the byte array and byte buffer, except when keep_bytes_i is high; in that case both keep their contents.
- R6: An accepted page write or erase drives ready_o low from the next cycle, for exactly BUSY_CYCLES cycles. ready_o then returns high.
- R7: While ready_o is low, load, page-write and erase strobes have no effect.
- R8: When strobes coincide in one accepted cycle, erase beats page write, and page write beats load. The losing strobes are dropped.
- R9: word_rdata_o shows the word at addr_i[9:0] and byte_rdata_o shows the byte at addr_i[6:0], both combinationally and in every cycle, including while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 10 | Address for loads, page select and reads |
| wdata_i | input | 16 | Load data (byte array uses bits 7:0) |
| target_i | input | 1 | 0 selects the word array, 1 the byte array |
| load_i | input | 1 | Load one buffer slot |
| page_write_i | input | 1 | Commit the buffer of the selected array |
| erase_i | input | 1 | Chip erase |
| keep_bytes_i | input | 1 | Protects the byte array during erase |
| word_rdata_o | output | 16 | Word array read data |
| byte_rdata_o | output | 8 | Byte array read data |
| ready_o | output | 1 | High when idle; low while an operation runs |

## Verification
The bench writes a word twice with overlapping bit patterns. A design that overwrites instead of merging would let a later write set bits back to one. It also commits the same page twice in a row, which exposes a design that forgets to refill its buffer with ones, and it selects a page through address bits 7:4 of the low byte, which exposes a design that takes the page from the high byte only. It fires every strobe during busy and all three strobes in one cycle: a design that queues, half-accepts or misorders them corrupts a page. An erase with the byte array protected catches a design that wipes it anyway or skips the word array.

// File: rtl/pfw_pkg.sv
// Package: shared types for the paged program store.
// Assumes: nothing beyond IEEE 1800-2017.
package pfw_pkg;
    typedef enum logic {
        TGT_WORD = 1'b0,
        TGT_BYTE = 1'b1
    } target_e;

    // Larger of two widths, used to size the shared address bus.
    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pfw_busy_timer.sv
// Busy timer: after a start pulse taken while idle, busy_o is held high
// for exactly CYCLES clock cycles and then released.
// Assumes: CYCLES >= 1; start_i pulses that arrive while busy are ignored.
module pfw_busy_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Load the countdown on start, count to zero, then drop busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o = busy_q;

    // R6: the countdown never leaves its window while busy.
    a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (int'(cnt_q) < CYCLES));

    // R6: an exhausted countdown releases busy on the next edge.
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == '0 && !start_i) |=> !busy_q);

    // R6: a start taken while idle raises busy.
    a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_q) |=> busy_q);
endmodule

// File: rtl/pfw_page_store.sv
// Page store: one array of 2**(IDX_W+PG_W) entries with a page buffer of
// 2**IDX_W slots. Loads fill buffer slots. A commit merges the whole buffer
// into one page with AND, so bits can only be cleared, and then refills the
// buffer with ones. An erase sets array and buffer to all ones.
// Assumes: at most one of load_i/commit_i/erase_i is high (arbitrated above).
module pfw_page_store #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    parameter int PG_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic                   commit_i,
    input  logic                   erase_i,
    input  logic [IDX_W+PG_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [DATA_W-1:0]      rdata_o
);
    localparam int SLOTS = 1 << IDX_W;
    localparam int DEPTH = 1 << (IDX_W + PG_W);

    logic [DATA_W-1:0] mem_q  [DEPTH];
    logic [DATA_W-1:0] buf_q  [SLOTS];
    logic [DATA_W-1:0] merged [SLOTS];
    logic [IDX_W-1:0]  slot;
    logic [PG_W-1:0]   page;
    logic              armed_q;

    assign slot = addr_i[IDX_W-1:0];
    assign page = addr_i[IDX_W+PG_W-1:IDX_W];

    // Per-slot merge of buffered data into the addressed page.
    for (genvar s = 0; s < SLOTS; s++) begin : g_merge
        assign merged[s] = mem_q[{page, IDX_W'(s)}] & buf_q[s];
    end

    // Array update: reset/erase to ones, page commit by AND-merge.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (commit_i) begin
            for (int s = 0; s < SLOTS; s++) begin
                mem_q[{page, IDX_W'(s)}] <= merged[s];
            end
        end
    end

    // Buffer update: ones after reset, erase or commit; slot write on load.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_i || commit_i) begin
            for (int s = 0; s < SLOTS; s++) begin
                buf_q[s] <= '1;
            end
        end else if (load_i) begin
            buf_q[slot] <= wdata_i;
        end
    end

    // Marks the first cycle whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign rdata_o = mem_q[addr_i];

    // R2: without commit or erase, a fixed address keeps its read value.
    a_r2_buffer_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !commit_i && !erase_i) |=>
            (!$stable(addr_i) || $stable(rdata_o)));

    // R3: outside an erase, no bit at a fixed address rises from 0 to 1.
    a_r3_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !erase_i) |=>
            (!$stable(addr_i) || ((rdata_o & ~$past(rdata_o)) == '0)));

    // R5: after an erase every location reads all ones.
    a_r5_erased: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (rdata_o == '1));
endmodule

// File: rtl/pfw_store_top.sv
// Top: arbitrates load / page-write / erase strobes (erase first, then page
// write, then load), gates them while busy, and routes them to the word and
// byte page stores. An erase with keep_bytes_i high spares the byte store.
// Assumes: strobes are single-cycle requests already synchronous to clk.
module pfw_store_top #(
    parameter int WORD_W      = 16,
    parameter int WORD_IDX_W  = 4,
    parameter int WORD_PG_W   = 6,
    parameter int BYTE_W      = 8,
    parameter int BYTE_IDX_W  = 2,
    parameter int BYTE_PG_W   = 5,
    parameter int BUSY_CYCLES = 64,
    localparam int WADDR_W    = WORD_IDX_W + WORD_PG_W,
    localparam int BADDR_W    = BYTE_IDX_W + BYTE_PG_W,
    localparam int ADDR_W     = pfw_pkg::max_w(WADDR_W, BADDR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              target_i,
    input  logic              load_i,
    input  logic              page_write_i,
    input  logic              erase_i,
    input  logic              keep_bytes_i,
    output logic [WORD_W-1:0] word_rdata_o,
    output logic [BYTE_W-1:0] byte_rdata_o,
    output logic              ready_o
);
    import pfw_pkg::*;

    logic busy;
    logic idle;
    logic to_byte;
    logic erase_go;
    logic commit_go;
    logic load_go;

    // Strobe arbitration and gating.
    always_comb begin
        idle      = !busy;
        to_byte   = (target_e'(target_i) == TGT_BYTE);
        erase_go  = idle && erase_i;
        commit_go = idle && !erase_i && page_write_i;
        load_go   = idle && !erase_i && !page_write_i && load_i;
    end

    pfw_busy_timer #(
        .CYCLES (BUSY_CYCLES)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (erase_go || commit_go),
        .busy_o  (busy)
    );

    pfw_page_store #(
        .DATA_W (WORD_W),
        .IDX_W  (WORD_IDX_W),
        .PG_W   (WORD_PG_W)
    ) i_word_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_go && !to_byte),
        .commit_i (commit_go && !to_byte),
        .erase_i  (erase_go),
        .addr_i   (addr_i[WADDR_W-1:0]),
        .wdata_i  (wdata_i),
        .rdata_o  (word_rdata_o)
    );

    pfw_page_store #(
        .DATA_W (BYTE_W),
        .IDX_W  (BYTE_IDX_W),
        .PG_W   (BYTE_PG_W)
    ) i_byte_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_go && to_byte),
        .commit_i (commit_go && to_byte),
        .erase_i  (erase_go && !keep_bytes_i),
        .addr_i   (addr_i[BADDR_W-1:0]),
        .wdata_i  (wdata_i[BYTE_W-1:0]),
        .rdata_o  (byte_rdata_o)
    );

    assign ready_o = !busy;

    // R6: an accepted page write or erase drops ready on the next edge.
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && (erase_i || page_write_i)) |=> !ready_o);

    // R7: while not ready, reads at a held address do not move.
    a_r7_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> (!$stable(addr_i) ||
                      ($stable(word_rdata_o) && $stable(byte_rdata_o))));
endmodule

// File: tb/test_pfw_store_top.sv
module test_pfw_store_top;
    localparam int BUSY = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        target = 1'b0;
    logic        load = 1'b0;
    logic        pwrite = 1'b0;
    logic        erase = 1'b0;
    logic        keep = 1'b0;
    logic [15:0] rd_word;
    logic [7:0]  rd_byte;
    logic        ready;

    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R1";

    logic [15:0] wm [1024];
    logic [7:0]  bm [128];
    logic [15:0] wbuf [16];
    logic [7:0]  bbuf [4];
    int          bcnt = 0;

    always #10 clk = ~clk;

    pfw_store_top #(.BUSY_CYCLES(BUSY)) i_pfw_store_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .target_i     (target),
        .load_i       (load),
        .page_write_i (pwrite),
        .erase_i      (erase),
        .keep_bytes_i (keep),
        .word_rdata_o (rd_word),
        .byte_rdata_o (rd_byte),
        .ready_o      (ready)
    );

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 1024; i++) wm[i] = 16'hFFFF;
        for (int i = 0; i < 128; i++)  bm[i] = 8'hFF;
        for (int k = 0; k < 16; k++)   wbuf[k] = 16'hFFFF;
        for (int k = 0; k < 4; k++)    bbuf[k] = 8'hFF;
        bcnt = 0;
    endfunction

    // Reference behaviour for one clock edge, from the requirements.
    function automatic void model_edge(input logic [9:0] a, input logic [15:0] d,
                                       input logic t, ld, pw, ce, kp);
        if (bcnt > 0) begin
            bcnt--;
        end else if (ce) begin
            for (int i = 0; i < 1024; i++) wm[i] = 16'hFFFF;
            for (int k = 0; k < 16; k++)   wbuf[k] = 16'hFFFF;
            if (!kp) begin
                for (int i = 0; i < 128; i++) bm[i] = 8'hFF;
                for (int k = 0; k < 4; k++)   bbuf[k] = 8'hFF;
            end
            bcnt = BUSY;
        end else if (pw) begin
            if (!t) begin
                for (int k = 0; k < 16; k++) begin
                    wm[{a[9:4], 4'(k)}] = wm[{a[9:4], 4'(k)}] & wbuf[k];
                    wbuf[k] = 16'hFFFF;
                end
            end else begin
                for (int k = 0; k < 4; k++) begin
                    bm[{a[6:2], 2'(k)}] = bm[{a[6:2], 2'(k)}] & bbuf[k];
                    bbuf[k] = 8'hFF;
                end
            end
            bcnt = BUSY;
        end else if (ld) begin
            if (!t) wbuf[a[3:0]] = d;
            else    bbuf[a[1:0]] = d[7:0];
        end
    endfunction

    // Apply one cycle of inputs, check outputs mid-cycle, then step the model.
    task automatic drive(input logic [9:0] a, input logic [15:0] d,
                         input logic t, ld, pw, ce, kp);
        @(negedge clk);
        addr = a; wdata = d; target = t; load = ld; pwrite = pw; erase = ce; keep = kp;
        #1;
        chk("word read", rd_word, wm[a]);
        chk("byte read", {8'h00, rd_byte}, {8'h00, bm[a[6:0]]});
        chk("ready", {15'h0, ready}, {15'h0, (bcnt == 0)});
        @(posedge clk);
        model_edge(a, d, t, ld, pw, ce, kp);
    endtask

    task automatic idle(input logic [9:0] a, input int n);
        for (int i = 0; i < n; i++) drive(a, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic sweep();
        for (int i = 0; i < 1024; i++) drive(10'(i), 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd24680));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        tag = "R1"; sweep();                                  // reset state, R9 reads

        tag = "R2";                                           // load into word buffer only
        drive({6'd5, 4'd3}, 16'h1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drive({6'd5, 4'd9}, 16'h0F0F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle({6'd5, 4'd3}, 2);
        tag = "R3";                                           // page from addr[9:4], low nibble ignored
        drive({6'd5, 4'd12}, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        tag = "R6"; idle({6'd5, 4'd3}, BUSY + 2);
        tag = "R4";                                           // empty buffer recommit changes nothing
        drive({6'd5, 4'd0}, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        idle({6'd5, 4'd9}, BUSY + 1);
        tag = "R3";                                           // bits only clear: 1234 & 00FF = 0034
        drive({6'd5, 4'd3}, 16'h00FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drive({6'd5, 4'd3}, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        idle({6'd5, 4'd3}, BUSY + 1);
        chk("R3 merged word", rd_word, 16'h0034);
        drive({6'd63, 4'd15}, 16'h8001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // last page, last slot
        drive({6'd63, 4'd0}, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        idle({6'd63, 4'd15}, BUSY + 1);

        tag = "R2";                                           // byte buffer
        drive(10'h01D, 16'hAB5A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(10'h01E, 16'h00C3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        tag = "R3";
        drive(10'h01C, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        idle(10'h01D, BUSY + 1);

        tag = "R7";                                           // strobes while busy dropped
        drive({6'd9, 4'd1}, 16'h1111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drive({6'd9, 4'd0}, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        drive({6'd9, 4'd2}, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drive({6'd9, 4'd0}, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        drive({6'd9, 4'd0}, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        idle({6'd9, 4'd2}, BUSY);
        drive({6'd9, 4'd0}, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // empty commit: slot 2 stays FFFF
        idle({6'd9, 4'd2}, BUSY + 1);

        tag = "R8";                                           // page write beats load
        drive({6'd7, 4'd4}, 16'h4444, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drive({6'd7, 4'd5}, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        idle({6'd7, 4'd5}, BUSY + 1);
        drive({6'd7, 4'd4}, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);  // buffer was cleared: no change
        idle({6'd7, 4'd4}, BUSY + 1);

        tag = "R5";                                           // erase with byte protection
        drive(10'h01D, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        idle(10'h01D, BUSY + 1);
        chk("R5 kept byte", {8'h00, rd_byte}, 16'h005A);
        chk("R5 erased word", rd_word, 16'hFFFF);
        tag = "R8";                                           // erase beats page write and load
        drive({6'd3, 4'd0}, 16'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        idle(10'h01D, BUSY + 1);
        chk("R5 erased byte", {8'h00, rd_byte}, 16'h00FF);

        tag = "R9";                                           // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [9:0] a;
            logic ld, pw, ce;
            a  = 10'($urandom);
            ld = ($urandom % 2) == 0;
            pw = ($urandom % 10) == 0;
            ce = ($urandom % 400) == 0;
            drive(a, 16'($urandom) | 16'($urandom), 1'($urandom), ld, pw, ce, 1'($urandom));
        end
        idle(10'h0, BUSY + 1);
        tag = "R3"; sweep();

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule